// File: doc/BRIEF.md
# Debug Halt Group Controller

This block is the halt-group logic of a multi-hart debug module. Each hart and each of sixteen external triggers carries a 5-bit group number, and a single configuration word sets these numbers. When a member hart enters the halted state, or when an external input trigger of a group is asserted, the controller requests a halt from every other running hart in that group. When a hart of a group halts, the controller also pulses the external output triggers of that group. Group 0 means "no group" and never propagates anything.

Software writes the configuration word to assign a group. The select bit chooses the target. Hart writes go to the hart named by the `hart_sel` port. Trigger writes go to the trigger named in the index field. A write only changes a group when its commit bit is set and it asks for a halt group. Resume-group requests are discarded. The readback word shows the stored assignment of the current target, so software can tell whether a setting was accepted.

Each hart has a small state machine with three states. `HG_RUN` means the hart is running and has no request. `HG_REQ` means a propagated halt request is being held. `HG_HALT` means the hart reports halted. The transitions are:
- RUN→HALT when `hart_halted` is seen.
- RUN→REQ when the hart's group fires and the hart is not halted.
- REQ→HALT when `hart_halted` is seen.
- HALT→RUN when `hart_halted` drops.

`halt_req` is high exactly in `HG_REQ`. A hart has "just halted" when `hart_halted` is high while its machine is not yet in `HG_HALT`.

Top module: `halt_group_ctrl`

## Requirements
- R1: After reset all groups read 0, `cfg_rdata` is 0, and `halt_req` and `ext_trig_out` are all 0.
- R2: The configuration word has these fields: group [4:0], resume-type bit [5] (0 = halt group), select bit [6] (0 = hart, 1 = trigger), trigger index [10:7] and commit bit [11]. A write with commit=1, type=0 and select=0 sets the group of hart `hart_sel`. Readback then shows that group with select 0.
- R3: A write with commit=1, type=0 and select=1 sets the group of the trigger named by the index field. Readback shows the group, select=1 and the index.
- R4: A write with commit=0 changes no group, but select and index are still captured for readback. `cfg_rdata` bits [11] and [5] always read 0.
- R5: A write with type=1 (resume group) changes no group, and readback keeps showing the previous group.
- R6: When a hart in group g≠0 is seen halted for the first time at a clock edge, every running hart of group g has `halt_req` high from that edge on.
- R7: While `ext_trig_in[t]` is high at a clock edge and trigger t is in group g≠0, every running hart of group g raises `halt_req` after that edge.
- R8: When a hart in group g≠0 first reports halted at an edge, `ext_trig_out[t]` is high for the following cycle only, for each trigger t in group g.
- R9: A hart or trigger in group 0 neither causes nor receives propagated halts or output pulses.
- R10: `halt_req` is held until the hart reports halted and drops after that edge. It is never raised for a hart that is already halted.
- R11: A propagated halt never reaches a hart of a different group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration word write enable |
| cfg_wdata | input | 12 | Configuration word written |
| hart_sel | input | HIDX_W (2) | Currently selected hart |
| cfg_rdata | output | 12 | Readback of the stored assignment of the current target |
| hart_halted | input | N_HARTS (4) | Halted status from each hart |
| halt_req | output | N_HARTS (4) | Propagated halt request to each hart |
| ext_trig_in | input | 16 | External input triggers, level sensitive |
| ext_trig_out | output | 16 | External output trigger pulses |

## Verification
The assertions assume that `hart_halted` is a level reported by each hart and that it stays high while the hart is stopped. They also assume `hart_sel` only changes between writes when the readback is compared. A request that appears must therefore trace back to a halted status or an input trigger in the previous cycle. The stimulus changes every input on the falling clock edge and holds it for whole cycles. Halts are raised and released as clean levels. Readback is compared with `hart_sel` held at the value used for the write.

// File: rtl/hg_pkg.sv
package hg_pkg;
    localparam int GRP_W    = 5;
    localparam int N_GRP    = 1 << GRP_W;
    localparam int TIDX_W   = 4;
    localparam int N_TRIG   = 1 << TIDX_W;
    // configuration word layout
    localparam int F_GRP    = 0;
    localparam int F_TYPE   = GRP_W;
    localparam int F_SEL    = GRP_W + 1;
    localparam int F_IDX    = GRP_W + 2;
    localparam int F_STB    = GRP_W + 2 + TIDX_W;
    localparam int CFG_W    = F_STB + 1;

    typedef logic [GRP_W-1:0]  grp_t;
    typedef logic [TIDX_W-1:0] tidx_t;

    typedef enum logic [1:0] {
        HG_RUN  = 2'd0,
        HG_REQ  = 2'd1,
        HG_HALT = 2'd2
    } hart_state_e;
endpackage

// File: rtl/hg_cfg_regs.sv
module hg_cfg_regs
    import hg_pkg::*;
#(
    parameter int N_HARTS = 4,
    parameter int HIDX_W  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [CFG_W-1:0]               cfg_wdata,
    input  logic [HIDX_W-1:0]              hart_sel,
    output logic [CFG_W-1:0]               cfg_rdata,
    output grp_t [N_HARTS-1:0]             hart_grp,
    output grp_t [N_TRIG-1:0]              trig_grp
);
    grp_t  wr_grp;
    tidx_t wr_idx;
    logic  wr_resume, wr_sel, wr_stb, commit, hart_ok;
    logic  sel_q;
    tidx_t idx_q;
    grp_t  rd_grp;

    assign wr_grp    = cfg_wdata[F_GRP +: GRP_W];
    assign wr_resume = cfg_wdata[F_TYPE];
    assign wr_sel    = cfg_wdata[F_SEL];
    assign wr_idx    = cfg_wdata[F_IDX +: TIDX_W];
    assign wr_stb    = cfg_wdata[F_STB];
    assign commit    = cfg_we && wr_stb && !wr_resume;
    assign hart_ok   = int'(hart_sel) < N_HARTS;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= 1'b0;
            idx_q    <= '0;
            hart_grp <= '0;
            trig_grp <= '0;
        end else if (cfg_we) begin
            sel_q <= wr_sel;
            idx_q <= wr_idx;
            if (commit) begin
                if (wr_sel)
                    trig_grp[wr_idx] <= wr_grp;
                else if (hart_ok)
                    hart_grp[hart_sel] <= wr_grp;
            end
        end
    end

    always_comb begin
        if (sel_q)
            rd_grp = trig_grp[idx_q];
        else if (hart_ok)
            rd_grp = hart_grp[hart_sel];
        else
            rd_grp = '0;
        cfg_rdata                   = '0;
        cfg_rdata[F_GRP +: GRP_W]   = rd_grp;
        cfg_rdata[F_SEL]            = sel_q;
        cfg_rdata[F_IDX +: TIDX_W]  = idx_q;
    end
endmodule

// File: rtl/hg_fire_map.sv
module hg_fire_map
    import hg_pkg::*;
#(
    parameter int N_HARTS = 4
) (
    input  grp_t [N_HARTS-1:0] hart_grp,
    input  grp_t [N_TRIG-1:0]  trig_grp,
    input  logic [N_HARTS-1:0] hart_rise,
    input  logic [N_TRIG-1:0]  ext_trig_in,
    output logic [N_GRP-1:0]   rise_by_grp,
    output logic [N_GRP-1:0]   fire_by_grp
);
    logic [N_GRP-1:0] trig_by_grp;

    always_comb begin
        rise_by_grp = '0;
        trig_by_grp = '0;
        for (int h = 0; h < N_HARTS; h++)
            if (hart_rise[h])
                rise_by_grp[hart_grp[h]] = 1'b1;
        for (int t = 0; t < N_TRIG; t++)
            if (ext_trig_in[t])
                trig_by_grp[trig_grp[t]] = 1'b1;
        // group 0 is "no group"
        rise_by_grp[0] = 1'b0;
        trig_by_grp[0] = 1'b0;
        fire_by_grp    = rise_by_grp | trig_by_grp;
    end
endmodule

// File: rtl/hg_hart_fsm.sv
module hg_hart_fsm
    import hg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halted,
    input  logic group_fire,
    output logic halt_req,
    output logic halt_rise
);
    hart_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= HG_RUN;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HG_RUN: begin
                if (halted)
                    state_d = HG_HALT;
                else if (group_fire)
                    state_d = HG_REQ;
            end
            HG_REQ: begin
                if (halted)
                    state_d = HG_HALT;
            end
            HG_HALT: begin
                if (!halted)
                    state_d = HG_RUN;
            end
            default: state_d = HG_RUN;
        endcase
    end

    always_comb begin
        halt_req  = 1'b0;
        halt_rise = 1'b0;
        unique case (state_q)
            HG_RUN:  halt_rise = halted;
            HG_REQ:  begin
                halt_req  = 1'b1;
                halt_rise = halted;
            end
            HG_HALT: halt_rise = 1'b0;
            default: halt_rise = 1'b0;
        endcase
    end
endmodule

// File: rtl/halt_group_ctrl.sv
module halt_group_ctrl
    import hg_pkg::*;
#(
    parameter int N_HARTS = 4,
    parameter int HIDX_W  = (N_HARTS > 1) ? $clog2(N_HARTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic [HIDX_W-1:0]  hart_sel,
    output logic [CFG_W-1:0]   cfg_rdata,
    input  logic [N_HARTS-1:0] hart_halted,
    output logic [N_HARTS-1:0] halt_req,
    input  logic [N_TRIG-1:0]  ext_trig_in,
    output logic [N_TRIG-1:0]  ext_trig_out
);
    grp_t [N_HARTS-1:0] hart_grp;
    grp_t [N_TRIG-1:0]  trig_grp;
    logic [N_HARTS-1:0] hart_rise;
    logic [N_GRP-1:0]   rise_by_grp, fire_by_grp;

    hg_cfg_regs #(.N_HARTS(N_HARTS), .HIDX_W(HIDX_W)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .hart_sel  (hart_sel),
        .cfg_rdata (cfg_rdata),
        .hart_grp  (hart_grp),
        .trig_grp  (trig_grp)
    );

    hg_fire_map #(.N_HARTS(N_HARTS)) map_i (
        .hart_grp    (hart_grp),
        .trig_grp    (trig_grp),
        .hart_rise   (hart_rise),
        .ext_trig_in (ext_trig_in),
        .rise_by_grp (rise_by_grp),
        .fire_by_grp (fire_by_grp)
    );

    for (genvar h = 0; h < N_HARTS; h++) begin : g_hart
        hg_hart_fsm fsm_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .halted     (hart_halted[h]),
            .group_fire (fire_by_grp[hart_grp[h]]),
            .halt_req   (halt_req[h]),
            .halt_rise  (hart_rise[h])
        );
    end

    for (genvar t = 0; t < N_TRIG; t++) begin : g_trig_out
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ext_trig_out[t] <= 1'b0;
            else
                ext_trig_out[t] <= rise_by_grp[trig_grp[t]];
        end
    end
endmodule

// File: rtl/halt_group_ctrl_chk.sv
module halt_group_ctrl_chk
    import hg_pkg::*;
#(
    parameter int N_HARTS = 4,
    parameter int HIDX_W  = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_we,
    input logic [CFG_W-1:GRP_W]   wr_ctl,
    input logic [HIDX_W-1:0]      hart_sel,
    input logic [CFG_W-1:0]       cfg_rdata,
    input logic [N_HARTS-1:0]     hart_halted,
    input logic [N_HARTS-1:0]     halt_req,
    input logic [N_TRIG-1:0]      ext_trig_in,
    input logic [N_TRIG-1:0]      ext_trig_out
);
    logic same_target, wr_resume, wr_stb;

    assign wr_resume   = wr_ctl[F_TYPE];
    assign wr_stb      = wr_ctl[F_STB];
    assign same_target = (wr_ctl[F_SEL] == cfg_rdata[F_SEL]) &&
                         (wr_ctl[F_IDX +: TIDX_W] == cfg_rdata[F_IDX +: TIDX_W]);

    // R4
    nostrobe_keeps_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !wr_stb && same_target |=>
            (hart_sel != $past(hart_sel)) || (cfg_rdata == $past(cfg_rdata)));

    // R5
    resume_keeps_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && wr_resume && same_target |=>
            (hart_sel != $past(hart_sel)) || (cfg_rdata == $past(cfg_rdata)));

    // R8
    out_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ext_trig_out) |-> $past(|hart_halted));

    for (genvar h = 0; h < N_HARTS; h++) begin : g_h
        // R10
        req_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
            halt_req[h] && hart_halted[h] |=> !halt_req[h]);
        // R10
        req_not_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(halt_req[h]) |-> $past(!hart_halted[h]));
        // R6 R7
        req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(halt_req[h]) |-> $past((|hart_halted) || (|ext_trig_in)));
    end
endmodule

bind halt_group_ctrl halt_group_ctrl_chk #(.N_HARTS(N_HARTS), .HIDX_W(HIDX_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .wr_ctl       (cfg_wdata[hg_pkg::CFG_W-1:hg_pkg::GRP_W]),
    .hart_sel     (hart_sel),
    .cfg_rdata    (cfg_rdata),
    .hart_halted  (hart_halted),
    .halt_req     (halt_req),
    .ext_trig_in  (ext_trig_in),
    .ext_trig_out (ext_trig_out)
);

// File: tb/halt_group_ctrl_tb_top.sv
module halt_group_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_wdata = '0;
    logic [1:0]  hart_sel = '0;
    logic [11:0] cfg_rdata;
    logic [3:0]  hart_halted = '0;
    logic [3:0]  halt_req;
    logic [15:0] ext_trig_in = '0;
    logic [15:0] ext_trig_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    halt_group_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .hart_sel     (hart_sel),
        .cfg_rdata    (cfg_rdata),
        .hart_halted  (hart_halted),
        .halt_req     (halt_req),
        .ext_trig_in  (ext_trig_in),
        .ext_trig_out (ext_trig_out)
    );

    // {hart_sel, write word, expected readback}
    localparam int NV = 11;
    localparam logic [25:0] VECS [NV] = '{
        {2'd0, 12'h803, 12'h003},  // R2 hart0 -> 3
        {2'd1, 12'h803, 12'h003},  // R2 hart1 -> 3
        {2'd2, 12'h805, 12'h005},  // R2 hart2 -> 5
        {2'd3, 12'h007, 12'h000},  // R4 no commit, hart3 stays 0
        {2'd0, 12'h943, 12'h143},  // R3 trig2 -> 3
        {2'd0, 12'hCC5, 12'h4C5},  // R3 trig9 -> 5
        {2'd0, 12'hCE6, 12'h4C5},  // R5 resume on trig9 ignored
        {2'd2, 12'h829, 12'h005},  // R5 resume on hart2 ignored
        {2'd0, 12'h243, 12'h240},  // R4 no commit on trig4
        {2'd0, 12'h85F, 12'h05F},  // R3 trig0 -> 31
        {2'd0, 12'h000, 12'h003}   // R2 back to hart view
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rdata", 32'(cfg_rdata), 0);
        rst_n = 1'b1;
        step();
        chk("R1 halt_req", 32'(halt_req), 0);
        chk("R1 ext_trig_out", 32'(ext_trig_out), 0);

        for (int i = 0; i < NV; i++) begin
            hart_sel  = VECS[i][25:24];
            cfg_wdata = VECS[i][23:12];
            cfg_we    = 1'b1;
            step();
            cfg_we = 1'b0;
            chk($sformatf("R2 R3 R4 R5 vector %0d", i), 32'(cfg_rdata), 32'(VECS[i][11:0]));
        end
        hart_sel = 2'd0;

        // R6 R8 R11: hart0 halts in group 3
        hart_halted = 4'b0001;
        step();
        chk("R6 req to hart1", 32'(halt_req), 32'h2);
        chk("R8 pulse trig2", 32'(ext_trig_out), 32'h4);
        step();
        chk("R8 pulse ends", 32'(ext_trig_out), 0);
        chk("R10 req held", 32'(halt_req), 32'h2);
        hart_halted = 4'b0011;
        step();
        chk("R10 req drops", 32'(halt_req), 0);
        chk("R8 pulse hart1", 32'(ext_trig_out), 32'h4);
        hart_halted = 4'b0000;
        step();
        step();

        // R7: trig9 fires, group 5 has hart2
        ext_trig_in = 16'h0200;
        step();
        ext_trig_in = '0;
        chk("R7 req to hart2", 32'(halt_req), 32'h4);
        chk("R7 no out pulse", 32'(ext_trig_out), 0);
        step();
        chk("R7 req held", 32'(halt_req), 32'h4);
        hart_halted = 4'b0100;
        step();
        chk("R10 req drops hart2", 32'(halt_req), 0);
        chk("R8 pulse trig9", 32'(ext_trig_out), 32'h0200);
        hart_halted = 4'b0000;
        step();

        // R9: group 0 trigger and group 0 hart
        ext_trig_in = 16'h0010;
        step();
        ext_trig_in = '0;
        chk("R9 trig in group 0", 32'(halt_req), 0);
        hart_halted = 4'b1000;
        step();
        chk("R9 hart3 out", 32'(ext_trig_out), 0);
        chk("R9 hart3 req", 32'(halt_req), 0);
        hart_halted = 4'b0000;
        step();

        // R10: input trigger hits already halted harts
        hart_halted = 4'b0011;
        step();
        chk("R10 simultaneous halt", 32'(halt_req), 0);
        ext_trig_in = 16'h0004;
        step();
        ext_trig_in = '0;
        chk("R10 halted not requested", 32'(halt_req), 0);
        hart_halted = 4'b0000;
        step();

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule